// File: doc/BRIEF.md
# Interrupt Restart Sequencer

This block is the core-side engine that moves a processor from normal execution into an interrupt service routine. At each instruction boundary, a strobe that the instruction sequencer raises one clock before the final cycle of the current instruction, it looks at the pending request. If a request is present, the block lets that final cycle complete and then runs a fixed restart sequence. The sequence saves the 16-bit return address on the stack one byte at a time, moves the stack pointer down by two and loads the program counter with the service address.

Two kinds of entry share the sequence. A vectored request carries its service address with it and goes straight to the stack writes. A non-vectored request first spends one cycle with the active-low acknowledge output asserted. In that cycle the requesting device places a one-byte restart opcode on the data bus. The restart number in that opcode, multiplied by eight, gives the service address. Accepting a maskable request also produces a one-cycle pulse that clears the core's global interrupt enable.

Top module: `irq_restart_seq`

## Requirements
- R1: After reset, and whenever no sequence runs, ackN is 1 and memWe, spLoad, pcLoad, done, ieClear and opError are 0.
- R2: A request is accepted only on a rising clock edge where instrBoundary and reqValid are both 1. A boundary with reqValid at 0 starts nothing. The cycle after acceptance is the finishing cycle of the current instruction: only ieClear may be active in it, and pcIn and spIn are captured at its end.
- R3: For a non-vectored request (reqVectored = 0), ackN is 0 for exactly one cycle, the cycle right after the finishing cycle. dataIn is captured as the restart opcode at the end of that cycle.
- R4: For a vectored request (reqVectored = 1), ackN stays 1 and the first stack write comes in the cycle right after the finishing cycle.
- R5: The return address is saved in two consecutive single-cycle writes. The first write stores bits 15:8 of the captured PC at address SP-1. The second stores bits 7:0 at address SP-2.
- R6: In the cycle right after the second write, spLoad, pcLoad and done are 1 for exactly one cycle, and spNext equals the captured SP minus 2.
- R7: A restart opcode of the form 11nnn111 (bits 7:6 = 11, bits 2:0 = 111) gives pcNext = 8*n, where n is taken from opcode bits 5:3.
- R8: Any other opcode gives pcNext = 0x0038 (restart number 7), with opError at 1 in the done cycle only.
- R9: For a vectored request, pcNext equals the reqVector value captured at acceptance, and dataIn has no effect.
- R10: ieClear is 1 for exactly one cycle, the finishing cycle, when the accepted request has reqMaskable = 1. It stays 0 for a request with reqMaskable = 0.
- R11: Boundaries that arrive while a sequence runs are ignored. The first boundary after done is sampled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrBoundary | input | 1 | Sample strobe, one clock before the last cycle of an instruction |
| reqValid | input | 1 | An interrupt request is pending |
| reqVectored | input | 1 | 1: request supplies its own vector; 0: restart opcode is fetched over the bus |
| reqMaskable | input | 1 | Request is maskable; accepting it clears the global enable |
| reqVector | input | 16 | Service address of a vectored request |
| dataIn | input | 8 | Data bus carrying the restart opcode during acknowledge |
| pcIn | input | 16 | Current program counter (return address) |
| spIn | input | 16 | Current stack pointer |
| ackN | output | 1 | Active-low interrupt acknowledge |
| memWe | output | 1 | Stack write strobe |
| memAddr | output | 16 | Stack write address |
| memWdata | output | 8 | Stack write byte |
| spLoad | output | 1 | Load spNext into the stack pointer |
| spNext | output | 16 | New stack pointer |
| pcLoad | output | 1 | Load pcNext into the program counter |
| pcNext | output | 16 | Service routine address |
| done | output | 1 | One-cycle pulse ending the sequence |
| ieClear | output | 1 | One-cycle pulse clearing the global interrupt enable |
| opError | output | 1 | The fetched opcode was not a restart opcode |

## Verification
The embedded assertions check on every cycle the properties that are local in time. Acknowledge is never active for a vectored entry. The low-byte write always follows the high-byte write, one address lower. Done lasts one cycle, comes right after a write, and leaves the stack pointer at the last written address. An error flag never appears without done, and a fetched target is always an aligned address within the first 64 bytes. Only the bench scenarios can show the full order and exact cycle of every event against the boundary that started it. They also show that a vectored entry ignores the bus, that boundaries inside a sequence are dropped, and that the right values arrive at the stack and program counter for each opcode, including malformed ones and a stack pointer that wraps.

// File: rtl/irq_restart_pkg.sv
package irq_restart_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FINISH,
    ST_ACK,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_LOAD
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capReq;   // latch vector of the accepted request
    logic capCtx;   // latch return PC and SP
    logic capOp;    // latch restart opcode from the bus
    logic pushHi;   // write high byte of return PC
    logic pushLo;   // write low byte of return PC
    logic loadRegs; // present new SP and PC
    logic selVec;   // target comes from the vector, not the opcode
  } seqStrobe_t;

endpackage

// File: rtl/irq_rst_decode.sv
module irq_rst_decode #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic [DATA_W-1:0] opcode,
  output logic [ADDR_W-1:0] target,
  output logic              badOp
);
  localparam int NUM_W   = 3;
  localparam int SHIFT_W = 3;  // 8 bytes per restart slot

  logic [NUM_W-1:0] rstNum;

  always_comb begin
    badOp  = !((opcode[7:6] == 2'b11) && (opcode[2:0] == 3'b111));
    rstNum = badOp ? {NUM_W{1'b1}} : opcode[5:3];
    target = '0;
    target[NUM_W+SHIFT_W-1:SHIFT_W] = rstNum;
  end

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_restart_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrBoundary,
  input  logic       reqValid,
  input  logic       reqVectored,
  input  logic       reqMaskable,
  output seqStrobe_t strb,
  output logic       ackN,
  output logic       ieClear,
  output logic       done
);

  seqState_t state, stateNxt;
  logic isVect, isMask;
  logic accept;

  assign accept = (state == ST_IDLE) && instrBoundary && reqValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      isVect <= 1'b0;
      isMask <= 1'b0;
    end else begin
      state <= stateNxt;
      if (accept) begin
        isVect <= reqVectored;
        isMask <= reqMaskable;
      end
    end
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:    if (accept) stateNxt = ST_FINISH;
      ST_FINISH:  stateNxt = isVect ? ST_PUSH_HI : ST_ACK;
      ST_ACK:     stateNxt = ST_PUSH_HI;
      ST_PUSH_HI: stateNxt = ST_PUSH_LO;
      ST_PUSH_LO: stateNxt = ST_LOAD;
      ST_LOAD:    stateNxt = ST_IDLE;
      default:    stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.capReq   = accept;
    strb.capCtx   = (state == ST_FINISH);
    strb.capOp    = (state == ST_ACK);
    strb.pushHi   = (state == ST_PUSH_HI);
    strb.pushLo   = (state == ST_PUSH_LO);
    strb.loadRegs = (state == ST_LOAD);
    strb.selVec   = isVect;
  end

  assign ackN    = !(state == ST_ACK);
  assign ieClear = (state == ST_FINISH) && isMask;
  assign done    = (state == ST_LOAD);

  AST_ACK_NOT_VECTORED: assert property (@(posedge clk) disable iff (!rstN)
    !ackN |-> !strb.selVec); // R4
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    !ackN |=> ackN); // R3
  AST_HI_THEN_LO: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushHi |=> strb.pushLo); // R5
  AST_LO_AFTER_HI: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushLo |-> $past(strb.pushHi)); // R5
  AST_DONE_AFTER_LO: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(strb.pushLo)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_IECLR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ieClear |=> !ieClear); // R10
  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capCtx || !ackN || strb.pushHi || strb.pushLo || done) |-> !strb.capReq); // R11

endmodule

// File: rtl/irq_seq_dpath.sv
module irq_seq_dpath
  import irq_restart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqVector,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] spIn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              spLoad,
  output logic [ADDR_W-1:0] spNext,
  output logic              pcLoad,
  output logic [ADDR_W-1:0] pcNext,
  output logic              opError
);
  localparam int BYTES = 2;
  localparam logic [ADDR_W-1:0] ONE   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] DEPTH = ADDR_W'(BYTES);

  logic [ADDR_W-1:0] retPc, spReg, vecReg, opTarget;
  logic [DATA_W-1:0] opReg;
  logic              opBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retPc  <= '0;
      spReg  <= '0;
      vecReg <= '0;
      opReg  <= '0;
    end else begin
      if (strb.capReq) vecReg <= reqVector;
      if (strb.capCtx) begin
        retPc <= pcIn;
        spReg <= spIn;
      end
      if (strb.capOp) opReg <= dataIn;
    end
  end

  irq_rst_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) decode_i (
    .opcode (opReg),
    .target (opTarget),
    .badOp  (opBad)
  );

  assign memWe    = strb.pushHi || strb.pushLo;
  assign memAddr  = strb.pushHi ? (spReg - ONE) : (spReg - DEPTH);
  assign memWdata = strb.pushHi ? retPc[ADDR_W-1:DATA_W] : retPc[DATA_W-1:0];
  assign spLoad   = strb.loadRegs;
  assign pcLoad   = strb.loadRegs;
  assign spNext   = spReg - DEPTH;
  assign pcNext   = strb.selVec ? vecReg : opTarget;
  assign opError  = strb.loadRegs && !strb.selVec && opBad;

  AST_LO_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushLo |-> memAddr == $past(memAddr) - ONE); // R5
  AST_SP_AT_LAST_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRegs |-> spNext == $past(memAddr)); // R6
  AST_ERR_ONLY_DONE: assert property (@(posedge clk) disable iff (!rstN)
    opError |-> strb.loadRegs); // R8
  AST_TARGET_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadRegs && !strb.selVec) |-> (pcNext[2:0] == 3'b000 && (pcNext >> 6) == '0)); // R7

endmodule

// File: rtl/irq_restart_seq.sv
module irq_restart_seq
  import irq_restart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrBoundary,
  input  logic              reqValid,
  input  logic              reqVectored,
  input  logic              reqMaskable,
  input  logic [ADDR_W-1:0] reqVector,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] spIn,
  output logic              ackN,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              spLoad,
  output logic [ADDR_W-1:0] spNext,
  output logic              pcLoad,
  output logic [ADDR_W-1:0] pcNext,
  output logic              done,
  output logic              ieClear,
  output logic              opError
);

  seqStrobe_t strb;

  irq_seq_ctrl ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .instrBoundary (instrBoundary),
    .reqValid      (reqValid),
    .reqVectored   (reqVectored),
    .reqMaskable   (reqMaskable),
    .strb          (strb),
    .ackN          (ackN),
    .ieClear       (ieClear),
    .done          (done)
  );

  irq_seq_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqVector (reqVector),
    .dataIn    (dataIn),
    .pcIn      (pcIn),
    .spIn      (spIn),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .spLoad    (spLoad),
    .spNext    (spNext),
    .pcLoad    (pcLoad),
    .pcNext    (pcNext),
    .opError   (opError)
  );

  AST_LOADS_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (spLoad && pcLoad && ackN && !memWe)); // R6
  AST_WRITE_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (ackN && !done && !ieClear)); // R5

endmodule

// File: tb/irq_restart_seq_tb_top.sv
module irq_restart_seq_tb_top;

  localparam int EV_ACK = 0, EV_WR = 1, EV_LOAD = 2, EV_IECLR = 3;

  typedef struct {
    int          kind;
    int          cyc;
    logic [15:0] a;
    logic [15:0] b;
    logic        err;
    string       req;
  } expItem_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic instrBoundary = 0, reqValid = 0, reqVectored = 0, reqMaskable = 0;
  logic [15:0] reqVector = '0, pcIn = '0, spIn = '0;
  logic [7:0]  dataIn = '0;
  logic ackN, memWe, spLoad, pcLoad, done, ieClear, opError;
  logic [15:0] memAddr, spNext, pcNext;
  logic [7:0]  memWdata;

  int checks = 0, errors = 0, cyc = 0;
  expItem_t expQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_restart_seq dut_i (
    .clk(clk), .rstN(rstN), .instrBoundary(instrBoundary), .reqValid(reqValid),
    .reqVectored(reqVectored), .reqMaskable(reqMaskable), .reqVector(reqVector),
    .dataIn(dataIn), .pcIn(pcIn), .spIn(spIn), .ackN(ackN), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .spLoad(spLoad), .spNext(spNext),
    .pcLoad(pcLoad), .pcNext(pcNext), .done(done), .ieClear(ieClear), .opError(opError)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pushExp(input int kind, input int c, input logic [15:0] a,
                         input logic [15:0] b, input logic err, input string req);
    expItem_t it;
    it.kind = kind; it.cyc = c; it.a = a; it.b = b; it.err = err; it.req = req;
    expQ.push_back(it);
  endtask

  // Monitor: every observed event must match the head of the expected queue
  task automatic observe(input int kind, input logic [15:0] a, input logic [15:0] b,
                         input logic err);
    expItem_t e;
    if (expQ.size() == 0) begin
      chk(0, "R2/R11", "unexpected event kind", kind, -1);
      return;
    end
    e = expQ.pop_front();
    chk(e.kind == kind, e.req, "event kind", kind, e.kind);
    chk(e.cyc == cyc, e.req, "event cycle", cyc, e.cyc);
    if (kind == EV_WR || kind == EV_LOAD) begin
      chk(a == e.a, e.req, kind == EV_WR ? "write addr" : "pcNext", a, e.a);
      chk(b == e.b, e.req, kind == EV_WR ? "write data" : "spNext", b, e.b);
    end
    if (kind == EV_LOAD) begin
      chk(err == e.err, e.req, "opError", err, e.err);
      chk(spLoad && pcLoad, "R6", "spLoad&pcLoad", {spLoad, pcLoad}, 3);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (ieClear) observe(EV_IECLR, '0, '0, 1'b0);
      if (!ackN)   observe(EV_ACK, '0, '0, 1'b0);
      if (memWe)   observe(EV_WR, memAddr, {8'h00, memWdata}, 1'b0);
      if (done)    observe(EV_LOAD, pcNext, spNext, opError);
      if (!done && (opError || spLoad || pcLoad))
        chk(0, "R1", "load/error outside done", {opError, spLoad, pcLoad}, 0);
    end
  end

  // Driver: raises one boundary and predicts every event of the sequence
  task automatic runReq(input bit vec, input bit mask, input logic [15:0] vector,
                        input logic [7:0] op, input logic [15:0] pc,
                        input logic [15:0] sp, input bit midBoundary,
                        input string req);
    int c, base;
    logic [15:0] tgt;
    bit bad;
    @(negedge clk);
    c = cyc;
    instrBoundary = 1; reqValid = 1; reqVectored = vec; reqMaskable = mask;
    reqVector = vector; dataIn = op; pcIn = pc; spIn = sp;
    bad = !(op[7:6] == 2'b11 && op[2:0] == 3'b111);
    tgt = vec ? vector : (bad ? 16'h0038 : {10'd0, op[5:3], 3'b000});
    if (mask) pushExp(EV_IECLR, c + 1, '0, '0, 0, "R10");
    base = c + 2;
    if (!vec) begin
      pushExp(EV_ACK, c + 2, '0, '0, 0, "R3");
      base = c + 3;
    end
    pushExp(EV_WR, base, sp - 16'd1, {8'h00, pc[15:8]}, 0, vec ? "R4/R5" : "R5");
    pushExp(EV_WR, base + 1, sp - 16'd2, {8'h00, pc[7:0]}, 0, "R5");
    pushExp(EV_LOAD, base + 2, tgt, sp - 16'd2, !vec && bad, req);
    @(negedge clk);
    instrBoundary = 0; reqValid = 0;
    if (vec) dataIn = ~op;  // bus noise must not matter on a vectored entry (R9)
    @(negedge clk);
    if (midBoundary) begin
      instrBoundary = 1; reqValid = 1;  // ignored while sequence runs (R11)
    end
    @(negedge clk);
    instrBoundary = 0; reqValid = 0;
    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, req, "pending expected events", expQ.size(), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ackN === 1'b1 && memWe === 1'b0 && done === 1'b0 && ieClear === 1'b0,
        "R1", "outputs in reset", {ackN, memWe, done, ieClear}, 4'b1000);
    rstN = 1;
    @(negedge clk);
    chk(ackN === 1'b1 && memWe === 1'b0 && spLoad === 1'b0 && pcLoad === 1'b0 &&
        opError === 1'b0, "R1", "outputs after reset", {ackN, memWe, spLoad, pcLoad}, 4'b1000);

    // R2: boundary without a request starts nothing (monitor flags any event)
    instrBoundary = 1; reqValid = 0; dataIn = 8'hEF;
    @(negedge clk);
    instrBoundary = 0;
    repeat (6) @(negedge clk);
    chk(ackN === 1'b1, "R2", "ackN after empty boundary", ackN, 1);

    // R2: request without a boundary starts nothing
    reqValid = 1;
    repeat (3) @(negedge clk);
    reqValid = 0;
    @(negedge clk);
    chk(memWe === 1'b0, "R2", "memWe without boundary", memWe, 0);

    runReq(0, 1, 16'h0000, 8'hEF, 16'h1234, 16'h8000, 0, "R7 rst5");
    runReq(0, 1, 16'h0000, 8'hC7, 16'hABCD, 16'h4000, 0, "R7 rst0");
    runReq(0, 0, 16'h0000, 8'hFF, 16'h00FF, 16'h2002, 0, "R7 rst7 non-maskable");
    runReq(0, 1, 16'h0000, 8'hE5, 16'h5A5A, 16'h3000, 0, "R8 bad opcode");
    runReq(0, 1, 16'h0000, 8'h2F, 16'h0102, 16'h3000, 0, "R8 bad high bits");
    runReq(1, 1, 16'h003C, 8'hC7, 16'hBEEF, 16'h7FFE, 0, "R9 vectored maskable");
    runReq(1, 0, 16'h0024, 8'hEF, 16'h4321, 16'h6000, 1, "R9 R11 vectored non-maskable");
    runReq(0, 1, 16'h0000, 8'hD7, 16'hCAFE, 16'h0001, 1, "R6 R11 sp wrap");
    // back-to-back entries: first boundary after done is accepted (R11)
    runReq(0, 0, 16'h0000, 8'hF7, 16'h7777, 16'h9000, 0, "R11 follow-up rst6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule